// File: doc/BRIEF.md
# Fabric Configuration Sequencer

This block steps an FPGA fabric through a full configuration handshake. A one-cycle `start_i` pulse launches it. The sequencer first checks the mode-select straps. It then confirms that the configuration pins are quiet and takes control of them through override enables. Next it pulses the active-low configuration request and watches the fabric echo that pulse on its status pin. After checking the configuration-done pin and its output enable, it opens the data and control paths for the external streamer.

When the host reports that the stream has ended, the sequencer can optionally run an early-user-mode wait, during which it forces a x1 clock-to-data ratio and requests all-ones sync words. It then waits for configuration-done, aborting if the status pin drops. It issues a burst of extra configuration clocks and waits for user mode. Finally it hands the pins back and performs a three-way final check.

Every wait is bounded by `TIMEOUT_CYC` clock cycles. At the end of a run, `done_o` rises and `err_o` holds the outcome until the next start. Sampled pins pass through a `SYNC_STAGES`-deep synchronizer.

Top module: `fabric_cfg_seq`

## Requirements
- R1: After reset the block is idle. Every drive is in its released state: `ncfg_o`=1, `nce_o`=1, `pr_req_o`=0, both path enables 0, both pin output enables 0, all four active-low override/driver enables 1. `done_o`=0 and `err_o`=0.
- R2: A mode-select value greater than 1 ends the run with `err_o`=1. The values 0 and 1 are accepted.
- R3: Before control is taken, and again after `nce_o` goes low, the block waits until both `ncfg_pin_i` and `nstatus_pin_i` read 1. If this does not happen within `TIMEOUT_CYC` cycles, the run ends with `err_o`=2.
- R4: `nce_o` is driven low only while both override enables (`ovr_cfg_n_o`, `ovr_ncfg_n_o`) are low.
- R5: `ncfg_o` is held low until `nstatus_pin_i` reads 0, then held high until it reads 1. Each wait has its own timeout, which ends the run with `err_o`=2. `ncfg_o` falls exactly once per run.
- R6: After the pulse, `cdone_pin_i` must be 0 and `cdone_oe_i` must be 1. Otherwise the run ends with `err_o`=3.
- R7: During the data phase, `data_phase_o`, `path_data_en_o` and `path_ctrl_en_o` are all 1. The phase ends on `data_done_i`.
- R8: While waiting for `cdone_pin_i`=1, a 0 on `nstatus_pin_i` ends the run with `err_o`=4. If neither event occurs within the timeout, the run ends with `err_o`=2.
- R9: After configuration-done, `extra_clk_o` is high for exactly `XCLK_N` cycles (15 by default). The block then waits for user mode, timing out with `err_o`=2.
- R10: Once user mode is seen, the drives are released. The run succeeds (`err_o`=0) only if user mode, `cdone_pin_i` and `nstatus_pin_i` all read 1. Otherwise `err_o`=3.
- R11: With `early_wait_en_i`=1, `ratio_x1_o` and `sync_req_o` are high after the data phase until `early_um_i` reads 1. A timeout ends the run with `err_o`=2. With `early_wait_en_i`=0, `sync_req_o` never rises.
- R12: When a run ends, all drives return to the released state. `done_o`=1 and `err_o` stay unchanged until the next start.
- R13: A start pulse that arrives while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| early_wait_en_i | input | 1 | Enables the early-user-mode wait |
| data_done_i | input | 1 | Host reports the end of the data stream |
| msel_i | input | MSEL_W | Mode-select straps |
| ncfg_pin_i | input | 1 | Sampled configuration-request pin |
| nstatus_pin_i | input | 1 | Sampled status pin |
| cdone_pin_i | input | 1 | Sampled configuration-done pin |
| cdone_oe_i | input | 1 | Configuration-done output-enable status |
| early_um_i | input | 1 | Early-user-mode flag |
| user_mode_i | input | 1 | User-mode flag |
| ncfg_o | output | 1 | Configuration request, active low |
| nce_o | output | 1 | Chip enable, active low |
| pr_req_o | output | 1 | Partial-reconfiguration request |
| ovr_cfg_n_o | output | 1 | Configuration override enable, active low |
| ovr_ncfg_n_o | output | 1 | Request-pin override enable, active low |
| drv_nstatus_n_o | output | 1 | Status-pin driver enable, active low |
| drv_cdone_n_o | output | 1 | Done-pin driver enable, active low |
| nstatus_oe_o | output | 1 | Status-pin output enable |
| cdone_oe_o | output | 1 | Done-pin output enable |
| path_data_en_o | output | 1 | Data path enable |
| path_ctrl_en_o | output | 1 | Control path enable |
| data_phase_o | output | 1 | Data streaming permitted |
| sync_req_o | output | 1 | Request an all-ones sync word |
| ratio_x1_o | output | 1 | Force clock-to-data ratio x1 |
| extra_clk_o | output | 1 | One extra configuration clock per cycle high |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished |
| err_o | output | 3 | Outcome: 0 ok, 1 mode, 2 timeout, 3 pin check, 4 status abort |

## Verification
A wrong state shows at the pins within a cycle, because every drive is decoded directly from the state register. The visible symptoms include a chip enable that goes low without overrides, a configuration-request pulse that never ends, or an extra-clock burst of the wrong length. A wrong transition usually becomes visible only later, as a wrong `err_o` code or a timeout after `TIMEOUT_CYC` cycles. For that reason, the bench checks the final code for each fault it injects, and also checks pulse counts and the released drives after every run.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;
   typedef enum logic [4:0] {
      S_IDLE, S_MODE, S_PINS_A, S_RELEASE, S_OVR, S_SELECT, S_PINS_B,
      S_PULSE_LO, S_PULSE_HI, S_PINCHK, S_DATA, S_EARLY, S_WAIT_CD,
      S_XCLK, S_WAIT_UM, S_FINISH, S_FINCHK
   } seq_state_e;

   typedef enum logic [2:0] {
      E_OK = 3'd0, E_MODE = 3'd1, E_TIMEOUT = 3'd2, E_PIN = 3'd3, E_ABORT = 3'd4
   } seq_err_e;

   localparam int unsigned F_NCFG  = 0;
   localparam int unsigned F_NST   = 1;
   localparam int unsigned F_CD    = 2;
   localparam int unsigned F_CDOE  = 3;
   localparam int unsigned F_EUM   = 4;
   localparam int unsigned F_UM    = 5;
   localparam int unsigned N_FLAGS = 6;
endpackage

// File: rtl/cfgseq_sync.sv
module cfgseq_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < int'(STAGES); i++) pipe[i] <= '0;
            end else begin
               pipe[0] <= d;
               for (int i = 1; i < int'(STAGES); i++) pipe[i] <= pipe[i-1];
            end
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/cfgseq_timer.sv
module cfgseq_timer #(
   parameter int unsigned LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic hit
);
   localparam int unsigned CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (clr)        cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
   end

   assign hit = (cnt == LAST);
endmodule

// File: rtl/fabric_cfg_seq.sv
module fabric_cfg_seq
   import cfgseq_pkg::*;
#(
   parameter int unsigned TIMEOUT_CYC = 1024,
   parameter int unsigned XCLK_N      = 15,
   parameter int unsigned MSEL_W      = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              early_wait_en_i,
   input  logic              data_done_i,
   input  logic [MSEL_W-1:0] msel_i,
   input  logic              ncfg_pin_i,
   input  logic              nstatus_pin_i,
   input  logic              cdone_pin_i,
   input  logic              cdone_oe_i,
   input  logic              early_um_i,
   input  logic              user_mode_i,
   output logic              ncfg_o,
   output logic              nce_o,
   output logic              pr_req_o,
   output logic              ovr_cfg_n_o,
   output logic              ovr_ncfg_n_o,
   output logic              drv_nstatus_n_o,
   output logic              drv_cdone_n_o,
   output logic              nstatus_oe_o,
   output logic              cdone_oe_o,
   output logic              path_data_en_o,
   output logic              path_ctrl_en_o,
   output logic              data_phase_o,
   output logic              sync_req_o,
   output logic              ratio_x1_o,
   output logic              extra_clk_o,
   output logic              busy_o,
   output logic              done_o,
   output logic [2:0]        err_o
);
   localparam int unsigned SW = N_FLAGS + MSEL_W;

   generate
      if (TIMEOUT_CYC < 2) begin : g_bad_tmo
         $error("TIMEOUT_CYC must be at least 2");
      end
      if (XCLK_N < 1) begin : g_bad_xclk
         $error("XCLK_N must be at least 1");
      end
      if (MSEL_W < 1) begin : g_bad_msel
         $error("MSEL_W must be at least 1");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must not exceed 4");
      end
   endgenerate

   logic [SW-1:0]     raw, syn;
   logic [MSEL_W-1:0] msel_s;
   logic              ncfg_s, nst_s, cd_s, cdoe_s, eum_s, um_s;

   assign raw = {msel_i, user_mode_i, early_um_i, cdone_oe_i,
                 cdone_pin_i, nstatus_pin_i, ncfg_pin_i};

   cfgseq_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
   );

   assign ncfg_s = syn[F_NCFG];
   assign nst_s  = syn[F_NST];
   assign cd_s   = syn[F_CD];
   assign cdoe_s = syn[F_CDOE];
   assign eum_s  = syn[F_EUM];
   assign um_s   = syn[F_UM];
   assign msel_s = syn[SW-1:N_FLAGS];

   seq_state_e state_q, state_d;
   seq_err_e   err_q, err_d;
   logic       done_q, done_d;
   logic       tmo_hit, burst_hit, step_clr;

   assign step_clr = (state_d != state_q);

   cfgseq_timer #(.LIMIT(TIMEOUT_CYC)) u_tmo (
      .clk(clk), .rst_n(rst_n), .clr(step_clr), .hit(tmo_hit)
   );
   cfgseq_timer #(.LIMIT(XCLK_N)) u_burst (
      .clk(clk), .rst_n(rst_n), .clr(step_clr), .hit(burst_hit)
   );

   always_comb begin
      state_d = state_q;
      err_d   = err_q;
      done_d  = done_q;
      unique case (state_q)
         S_IDLE: if (start_i) begin
            state_d = S_MODE; err_d = E_OK; done_d = 1'b0;
         end
         S_MODE:
            if (msel_s > MSEL_W'(1)) begin
               state_d = S_IDLE; err_d = E_MODE; done_d = 1'b1;
            end else state_d = S_PINS_A;
         S_PINS_A, S_PINS_B:
            if (ncfg_s && nst_s)
               state_d = (state_q == S_PINS_A) ? S_RELEASE : S_PULSE_LO;
            else if (tmo_hit) begin
               state_d = S_IDLE; err_d = E_TIMEOUT; done_d = 1'b1;
            end
         S_RELEASE: state_d = S_OVR;
         S_OVR:     state_d = S_SELECT;
         S_SELECT:  state_d = S_PINS_B;
         S_PULSE_LO:
            if (!nst_s) state_d = S_PULSE_HI;
            else if (tmo_hit) begin
               state_d = S_IDLE; err_d = E_TIMEOUT; done_d = 1'b1;
            end
         S_PULSE_HI:
            if (nst_s) state_d = S_PINCHK;
            else if (tmo_hit) begin
               state_d = S_IDLE; err_d = E_TIMEOUT; done_d = 1'b1;
            end
         S_PINCHK:
            if (!cd_s && cdoe_s) state_d = S_DATA;
            else begin
               state_d = S_IDLE; err_d = E_PIN; done_d = 1'b1;
            end
         S_DATA:
            if (data_done_i) state_d = early_wait_en_i ? S_EARLY : S_WAIT_CD;
         S_EARLY:
            if (eum_s) state_d = S_WAIT_CD;
            else if (tmo_hit) begin
               state_d = S_IDLE; err_d = E_TIMEOUT; done_d = 1'b1;
            end
         S_WAIT_CD:
            if (cd_s) state_d = S_XCLK;
            else if (!nst_s) begin
               state_d = S_IDLE; err_d = E_ABORT; done_d = 1'b1;
            end else if (tmo_hit) begin
               state_d = S_IDLE; err_d = E_TIMEOUT; done_d = 1'b1;
            end
         S_XCLK: if (burst_hit) state_d = S_WAIT_UM;
         S_WAIT_UM:
            if (um_s) state_d = S_FINISH;
            else if (tmo_hit) begin
               state_d = S_IDLE; err_d = E_TIMEOUT; done_d = 1'b1;
            end
         S_FINISH: state_d = S_FINCHK;
         S_FINCHK: begin
            state_d = S_IDLE; done_d = 1'b1;
            err_d   = (um_s && cd_s && nst_s) ? E_OK : E_PIN;
         end
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         err_q   <= E_OK;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         err_q   <= err_d;
         done_q  <= done_d;
      end
   end

   logic owned, selected, paths_on;
   assign owned    = (state_q >= S_OVR)    && (state_q <= S_WAIT_UM);
   assign selected = (state_q >= S_SELECT) && (state_q <= S_WAIT_UM);
   assign paths_on = (state_q >= S_DATA)   && (state_q <= S_WAIT_UM);

   assign ncfg_o          = (state_q != S_PULSE_LO);
   assign nce_o           = !selected;
   assign pr_req_o        = 1'b0;
   assign ovr_cfg_n_o     = !owned;
   assign ovr_ncfg_n_o    = !owned;
   assign drv_nstatus_n_o = 1'b1;
   assign drv_cdone_n_o   = 1'b1;
   assign nstatus_oe_o    = 1'b0;
   assign cdone_oe_o      = 1'b0;
   assign path_data_en_o  = paths_on;
   assign path_ctrl_en_o  = paths_on;
   assign data_phase_o    = (state_q == S_DATA);
   assign sync_req_o      = (state_q == S_EARLY);
   assign ratio_x1_o      = (state_q == S_EARLY);
   assign extra_clk_o     = (state_q == S_XCLK);
   assign busy_o          = (state_q != S_IDLE);
   assign done_o          = done_q;
   assign err_o           = err_q;
endmodule

// File: rtl/fabric_cfg_seq_chk.sv
module fabric_cfg_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic       ncfg_o,
   input logic       nce_o,
   input logic       pr_req_o,
   input logic       ovr_cfg_n_o,
   input logic       ovr_ncfg_n_o,
   input logic       path_data_en_o,
   input logic       path_ctrl_en_o,
   input logic       sync_req_o,
   input logic       ratio_x1_o,
   input logic       busy_o,
   input logic       done_o,
   input logic [2:0] err_o
);
   assert_idle_released_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (nce_o && ncfg_o && !path_data_en_o && ovr_cfg_n_o && ovr_ncfg_n_o));

   assert_select_needs_ovr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !nce_o |-> (!ovr_cfg_n_o && !ovr_ncfg_n_o));

   assert_paths_selected_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (path_data_en_o || path_ctrl_en_o) |-> !nce_o);

   assert_pulse_selected_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !ncfg_o |-> (!nce_o && busy_o && !pr_req_o));

   assert_err_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> ($stable(err_o) && $stable(done_o)));

   assert_err_implies_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o != 3'd0) |-> (done_o && !busy_o));

   assert_sync_forces_x1_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sync_req_o |-> (ratio_x1_o && path_data_en_o));
endmodule

bind fabric_cfg_seq fabric_cfg_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .ncfg_o(ncfg_o), .nce_o(nce_o),
   .pr_req_o(pr_req_o), .ovr_cfg_n_o(ovr_cfg_n_o), .ovr_ncfg_n_o(ovr_ncfg_n_o),
   .path_data_en_o(path_data_en_o), .path_ctrl_en_o(path_ctrl_en_o),
   .sync_req_o(sync_req_o), .ratio_x1_o(ratio_x1_o), .busy_o(busy_o),
   .done_o(done_o), .err_o(err_o)
);

// File: tb/tb_fabric_cfg_seq.sv
module tb_fabric_cfg_seq;
   localparam int TMO = 64;
   localparam int XN  = 15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0, early_wait_en_i = 1'b0, data_done_i = 1'b0;
   logic [2:0] msel_i = 3'd0;
   logic ncfg_pin_i, nstatus_pin_i, cdone_pin_i, cdone_oe_i, early_um_i, user_mode_i;
   logic ncfg_o, nce_o, pr_req_o, ovr_cfg_n_o, ovr_ncfg_n_o, drv_nstatus_n_o, drv_cdone_n_o;
   logic nstatus_oe_o, cdone_oe_o, path_data_en_o, path_ctrl_en_o, data_phase_o;
   logic sync_req_o, ratio_x1_o, extra_clk_o, busy_o, done_o;
   logic [2:0] err_o;

   always #10 clk = ~clk;

   fabric_cfg_seq #(.TIMEOUT_CYC(TMO), .XCLK_N(XN), .MSEL_W(3), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .early_wait_en_i(early_wait_en_i),
      .data_done_i(data_done_i), .msel_i(msel_i), .ncfg_pin_i(ncfg_pin_i),
      .nstatus_pin_i(nstatus_pin_i), .cdone_pin_i(cdone_pin_i), .cdone_oe_i(cdone_oe_i),
      .early_um_i(early_um_i), .user_mode_i(user_mode_i), .ncfg_o(ncfg_o), .nce_o(nce_o),
      .pr_req_o(pr_req_o), .ovr_cfg_n_o(ovr_cfg_n_o), .ovr_ncfg_n_o(ovr_ncfg_n_o),
      .drv_nstatus_n_o(drv_nstatus_n_o), .drv_cdone_n_o(drv_cdone_n_o),
      .nstatus_oe_o(nstatus_oe_o), .cdone_oe_o(cdone_oe_o), .path_data_en_o(path_data_en_o),
      .path_ctrl_en_o(path_ctrl_en_o), .data_phase_o(data_phase_o), .sync_req_o(sync_req_o),
      .ratio_x1_o(ratio_x1_o), .extra_clk_o(extra_clk_o), .busy_o(busy_o),
      .done_o(done_o), .err_o(err_o)
   );

   // Fault codes for the fabric model
   localparam int F_NONE = 0, F_PINSTK = 1, F_NOFALL = 2, F_NORISE = 3, F_CDHI = 4,
                  F_CDOE = 5, F_NSTDROP = 6, F_NOCD = 7, F_NOUM = 8, F_FINAL = 9,
                  F_NOEUM = 10;

   // vector: msel[10:8] fault[7:4] early[3] expected error[2:0]
   localparam int NV = 14;
   localparam logic [10:0] VEC [NV] = '{
      {3'd0, 4'd0,  1'b0, 3'd0}, {3'd1, 4'd0,  1'b1, 3'd0},
      {3'd2, 4'd0,  1'b0, 3'd1}, {3'd7, 4'd0,  1'b0, 3'd1},
      {3'd0, 4'd1,  1'b0, 3'd2}, {3'd0, 4'd2,  1'b0, 3'd2},
      {3'd1, 4'd3,  1'b0, 3'd2}, {3'd0, 4'd4,  1'b0, 3'd3},
      {3'd0, 4'd5,  1'b0, 3'd3}, {3'd0, 4'd6,  1'b0, 3'd4},
      {3'd0, 4'd7,  1'b0, 3'd2}, {3'd0, 4'd8,  1'b0, 3'd2},
      {3'd0, 4'd9,  1'b0, 3'd3}, {3'd0, 4'd10, 1'b1, 3'd2}
   };

   int fault = F_NONE;
   logic mdl_clr = 1'b1;
   logic nst_m = 1'b1, cd_m = 1'b0, eum_m = 1'b0, um_m = 1'b0, fell = 1'b0, post = 1'b0;
   logic prev_ncfg = 1'b1;
   int dcnt = 0, pcnt = 0, syncs = 0, xclks = 0, falls = 0, dp_ok = 0;

   assign ncfg_pin_i    = (fault == F_PINSTK) ? 1'b0 : ncfg_o;
   assign nstatus_pin_i = nst_m;
   assign cdone_pin_i   = (fault == F_CDHI) ? 1'b1 : cd_m;
   assign cdone_oe_i    = (fault == F_CDOE) ? 1'b0 : 1'b1;
   assign early_um_i    = eum_m;
   assign user_mode_i   = um_m;

   // Behavioural fabric, updated away from the active edge
   always @(negedge clk) begin
      if (mdl_clr) begin
         nst_m = 1'b1; cd_m = 1'b0; eum_m = 1'b0; um_m = 1'b0; fell = 1'b0; post = 1'b0;
         prev_ncfg = 1'b1; dcnt = 0; pcnt = 0; syncs = 0; xclks = 0; falls = 0; dp_ok = 0;
         data_done_i = 1'b0;
      end else begin
         if (prev_ncfg && !ncfg_o) falls++;
         prev_ncfg = ncfg_o;
         if (!ncfg_o) fell = 1'b1;
         if (fault == F_NOFALL)      nst_m = 1'b1;
         else if (fault == F_NORISE) nst_m = fell ? 1'b0 : ncfg_o;
         else                        nst_m = ncfg_o;
         data_done_i = 1'b0;
         if (data_phase_o) begin
            if (path_data_en_o && path_ctrl_en_o) dp_ok++;
            dcnt++;
            if (dcnt == 4) begin data_done_i = 1'b1; post = 1'b1; end
         end
         if (post) begin
            pcnt++;
            if (pcnt >= 5 && fault != F_NOCD) cd_m = 1'b1;
            if (fault == F_NSTDROP) nst_m = 1'b0;
         end
         if (sync_req_o) syncs++;
         eum_m = (syncs >= 3) && (fault != F_NOEUM);
         if (extra_clk_o) xclks++;
         um_m = (xclks >= XN) && (fault != F_NOUM);
         if (fault == F_FINAL && um_m) nst_m = 1'b0;
      end
   end

   int checks = 0, errors = 0, cyc = 0;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic string req_of(input int f, input int m);
      if (m > 1) return "R2";
      case (f)
         F_PINSTK: return "R3";
         F_NOFALL, F_NORISE: return "R5";
         F_CDHI, F_CDOE: return "R6";
         F_NSTDROP, F_NOCD: return "R8";
         F_NOUM: return "R9";
         F_FINAL: return "R10";
         F_NOEUM: return "R11";
         default: return "R10";
      endcase
   endfunction

   task automatic released(input string req);
      chk(req, {ncfg_o, nce_o, pr_req_o, ovr_cfg_n_o, ovr_ncfg_n_o, drv_nstatus_n_o,
                drv_cdone_n_o, nstatus_oe_o, cdone_oe_o, path_data_en_o, path_ctrl_en_o},
          11'b11011110000);
   endtask

   task automatic run_vec(input logic [10:0] v);
      int exp_err, wait_n;
      string rq;
      msel_i = v[10:8]; fault = int'(v[7:4]); early_wait_en_i = v[3]; exp_err = int'(v[2:0]);
      rq = req_of(fault, int'(v[10:8]));
      mdl_clr = 1'b1;
      repeat (4) @(negedge clk);
      mdl_clr = 1'b0;
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      if (exp_err == 0) begin
         repeat (8) @(negedge clk);
         start_i = 1'b1;          // R13: ignored while busy
         @(negedge clk); start_i = 1'b0;
      end
      wait_n = 0;
      while (!done_o && wait_n < 3000) begin @(negedge clk); wait_n++; end
      chk({rq, " done"}, int'(done_o), 1);
      chk({rq, " error code"}, int'(err_o), exp_err);
      released("R12 drives after run");
      if (exp_err == 0) begin
         chk("R9 extra clocks", xclks, XN);
         chk("R13 single pulse", falls, 1);
         chk("R7 data phase paths", dp_ok, 4);
         chk("R11 sync requests", (syncs > 0) ? 1 : 0, int'(v[3]));
      end
   endtask

   initial begin
      while (cyc < 150000) begin @(posedge clk); cyc++; end
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 done at reset", int'(done_o), 0);
      chk("R1 err at reset", int'(err_o), 0);
      released("R1 drives at reset");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 idle after reset", int'(busy_o), 0);
      for (int i = 0; i < NV; i++) run_vec(VEC[i]);
      // R12: code held with no start
      repeat (20) @(negedge clk);
      chk("R12 code held", int'(err_o), 2);
      chk("R12 done held", int'(done_o), 1);
      // R2 boundary: msel 1 accepted, then reset mid-run
      msel_i = 3'd1; fault = F_NONE; early_wait_en_i = 1'b0;
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      chk("R12 start clears done", int'(done_o), 0);
      repeat (6) @(negedge clk);
      chk("R2 msel 1 accepted", int'(busy_o), 1);
      rst_n = 1'b0;
      @(negedge clk);
      released("R1 drives in reset");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule